// File: doc/BRIEF.md
# Processor Memory Port with Completion Handshake

This unit sits between a processor's internal data bus and an external memory bus. It holds the memory address register and the memory data register. The data register can be loaded from the internal bus or from the memory read lines. It can also present its contents on the internal bus and on the memory write lines, and each of these four paths has its own enable.

A control sequencer drives one set of single-cycle strobes per step. A read is started by loading the address register and raising the read strobe in the same step. A write loads the address first. It then loads the data register from the internal bus together with the write strobe. It then drives the data register onto the memory lines while it waits. The request line stays high on the memory bus until the memory's done signal is seen during a wait step. While the sequencer waits, a stall output holds it in place.

Strobe combinations that break the step rules are rejected. Such a step is ignored as a whole, and an error flag pulses for one cycle.

Top module: `mem_port_unit`

## Requirements
- R1: After a synchronous active-low reset, `mem_rd`, `mem_wr`, `stall` and `strobe_err` are low, and the address and data registers are zero.
- R2: In a legal step with `mar_ld` high, the address register takes `ibus_in[AW-1:0]`, and `mem_addr` shows it from the next cycle. In any other step the address register keeps its value.
- R3: In a legal step with `mdr_ld_int` high, the data register takes `ibus_in`. `ibus_out` always shows the data register. `ibus_oe` is high in exactly the legal steps that have `mdr_drv_int` high.
- R4: A legal step with `rd_req` high and no request open raises `mem_rd` from the next cycle. `mem_rd` stays high, even if `mem_done` rises outside a wait step, until a legal step with `wait_done` and `mem_done` both high. It is low from the cycle after that step. `mem_rd` and `mem_wr` are never high together.
- R5: In a legal step with `mdr_ld_ext` and `mem_done` both high, the data register takes `mem_rdata`. If `mdr_ld_ext` is high while `mem_done` is low, the data register is unchanged.
- R6: A legal step with `wr_req` high and no request open raises `mem_wr` from the next cycle, with the same hold and release rule as R4. `mem_wdata` always shows the data register. `mem_wdata_oe` is high in exactly the legal steps that have `mdr_drv_ext` high.
- R7: `stall` is high in the same cycle as a legal step that has `wait_done` high, a request open and `mem_done` low. It is low in every other cycle, including a wait step with no request open.
- R8: A step is illegal if it has any of these combinations: `rd_req` with `wr_req`; `rd_req` or `wr_req` with `wait_done`; `mdr_ld_int` with `mdr_ld_ext`; `mdr_ld_int` with `mdr_drv_int`. `strobe_err` is high in the cycle after an illegal step and low in the cycle after a legal step.
- R9: An illegal step changes no register and opens no request. It also keeps `ibus_oe`, `mem_wdata_oe` and `stall` low.
- R10: A step with `rd_req` or `wr_req` high while a request is already open is illegal. It raises `strobe_err` and leaves the open request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ibus_in | input | DW | Internal bus value offered to the registers |
| ibus_out | output | DW | Data register contents toward the internal bus |
| ibus_oe | output | 1 | Data register drives the internal bus this step |
| mar_ld | input | 1 | Load the address register from the internal bus |
| mdr_ld_int | input | 1 | Load the data register from the internal bus |
| mdr_ld_ext | input | 1 | Load the data register from the memory read lines when done |
| mdr_drv_int | input | 1 | Drive the data register onto the internal bus |
| mdr_drv_ext | input | 1 | Drive the data register onto the memory write lines |
| rd_req | input | 1 | Start a memory read |
| wr_req | input | 1 | Start a memory write |
| wait_done | input | 1 | Sequencer waits for memory completion this step |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read request to memory |
| mem_wr | output | 1 | Write request to memory |
| mem_wdata | output | DW | Write data to memory |
| mem_wdata_oe | output | 1 | Write data lines are driven |
| mem_rdata | input | DW | Read data from memory |
| mem_done | input | 1 | Memory completion |
| stall | output | 1 | Hold the sequencer |
| strobe_err | output | 1 | Previous step had an illegal strobe combination |

## Verification
The bench tries all 256 strobe patterns with no request open. For each one it predicts legality, register updates, enables and the new request. A design that missed one forbidden pair would load a register or open a request in a step it must ignore. Directed sequences cover several points. One is a read held across several stalled wait cycles. Another is `mem_done` rising outside a wait step: a design that released there would drop the request and lose the read data. A third is a new request while one is open: a design that accepted it would overwrite the open request. The last is a wait with no request open: a design that stalled there would hang the sequencer.

// File: rtl/mpu_pkg.sv
// Package: shared types for the processor memory port.
// Assumes: one strobe bundle per cycle from the control sequencer.
package mpu_pkg;

    // Strobe bundle presented by the sequencer in one step.
    typedef struct packed {
        logic mar_ld;
        logic mdr_ld_int;
        logic mdr_ld_ext;
        logic mdr_drv_int;
        logic mdr_drv_ext;
        logic rd;
        logic wr;
        logic wt;
    } strobe_t;

    // Open memory request.
    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2
    } req_state_e;

endpackage

// File: rtl/mpu_strobe_check.sv
// Module: decides whether the current strobe step obeys the step rules.
// Assumes: busy is high while a memory request is open.
module mpu_strobe_check
    import mpu_pkg::*;
(
    input  strobe_t stb,
    input  logic    busy,
    output logic    legal
);

    logic rw_clash;
    logic req_with_wait;
    logic mdr_dual_load;
    logic mdr_in_out;
    logic req_overlap;

    // Flag each forbidden combination separately, then merge them.
    always_comb begin
        rw_clash      = stb.rd & stb.wr;
        req_with_wait = (stb.rd | stb.wr) & stb.wt;
        mdr_dual_load = stb.mdr_ld_int & stb.mdr_ld_ext;
        mdr_in_out    = stb.mdr_ld_int & stb.mdr_drv_int;
        req_overlap   = (stb.rd | stb.wr) & busy;
        legal = ~(rw_clash | req_with_wait | mdr_dual_load | mdr_in_out | req_overlap);
    end

endmodule

// File: rtl/mpu_req_ctrl.sv
// Module: holds the open memory request, produces stall and the error pulse.
// Assumes: memory keeps mem_done high until it sees the request drop.
module mpu_req_ctrl
    import mpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t stb,
    input  logic    legal,
    input  logic    mem_done,
    output logic    busy,
    output logic    mem_rd,
    output logic    mem_wr,
    output logic    stall,
    output logic    strobe_err
);

    req_state_e state_q, state_d;
    logic       err_q;
    logic       release_req;

    // The request is released only in a legal wait step that sees completion.
    always_comb begin
        release_req = legal & stb.wt & mem_done & (state_q != REQ_IDLE);
    end

    // Next-state choice for the open request.
    always_comb begin
        state_d = state_q;
        if (release_req) begin
            state_d = REQ_IDLE;
        end else if (legal && state_q == REQ_IDLE) begin
            if (stb.rd) begin
                state_d = REQ_READ;
            end else if (stb.wr) begin
                state_d = REQ_WRITE;
            end
        end
    end

    // Request state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // One-cycle error pulse after an illegal step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= ~legal;
        end
    end

    // Output decode of the request lines and stall.
    always_comb begin
        busy       = (state_q != REQ_IDLE);
        mem_rd     = (state_q == REQ_READ);
        mem_wr     = (state_q == REQ_WRITE);
        stall      = legal & stb.wt & busy & ~mem_done;
        strobe_err = err_q;
    end

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R4

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !(stb.wt && mem_done)) |=> mem_rd); // R4

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !(stb.wt && mem_done)) |=> mem_wr); // R6

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && legal && stb.wt && mem_done) |=> !(mem_rd || mem_wr)); // R4

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> strobe_err); // R8

    AST_IGNORED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !legal) |=> !busy); // R9

    AST_OVERLAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && (stb.rd || stb.wr) && !stb.wt) |=> mem_rd); // R10

    AST_STALL_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (mem_rd || mem_wr)); // R7

endmodule

// File: rtl/mpu_data_path.sv
// Module: address and data registers with their gated load and drive paths.
// Assumes: legal comes from the strobe checker; illegal steps touch nothing.
module mpu_data_path
    import mpu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       stb,
    input  logic          legal,
    input  logic          mem_done,
    input  logic [DW-1:0] ibus_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mdr_val,
    output logic          ibus_oe,
    output logic          mem_wdata_oe
);

    localparam int AW_USED = (AW < DW) ? AW : DW;

    logic [AW-1:0] mar_q;
    logic [DW-1:0] mdr_q;
    logic [AW-1:0] mar_src;
    logic          mar_en;
    logic          mdr_int_en;
    logic          mdr_ext_en;

    // Qualify every enable with step legality.
    always_comb begin
        mar_en       = legal & stb.mar_ld;
        mdr_int_en   = legal & stb.mdr_ld_int;
        mdr_ext_en   = legal & stb.mdr_ld_ext & mem_done;
        ibus_oe      = legal & stb.mdr_drv_int;
        mem_wdata_oe = legal & stb.mdr_drv_ext;
    end

    // Address source: low bits of the bus, zero-padded if the bus is narrower.
    generate
        if (AW > DW) begin : g_pad
            always_comb mar_src = {{(AW - DW){1'b0}}, ibus_in};
        end else begin : g_trunc
            always_comb mar_src = ibus_in[AW_USED-1:0];
        end
    endgenerate

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (mar_en) begin
            mar_q <= mar_src;
        end
    end

    // Data register with internal and external load paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
        end else if (mdr_int_en) begin
            mdr_q <= ibus_in;
        end else if (mdr_ext_en) begin
            mdr_q <= mem_rdata;
        end
    end

    // Register outputs.
    always_comb begin
        mem_addr = mar_q;
        mdr_val  = mdr_q;
    end

    AST_MAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mar_en |=> $stable(mem_addr)); // R2

    AST_MDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mdr_int_en || mdr_ext_en) |=> $stable(mdr_val)); // R5

    AST_NO_DRIVE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> !(ibus_oe || mem_wdata_oe)); // R9

endmodule

// File: rtl/mem_port_unit.sv
// Module: top of the processor memory port; bundles strobes and wires parts.
// Assumes: one strobe set per cycle; memory holds mem_done until request drops.
module mem_port_unit
    import mpu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ibus_in,
    output logic [DW-1:0] ibus_out,
    output logic          ibus_oe,
    input  logic          mar_ld,
    input  logic          mdr_ld_int,
    input  logic          mdr_ld_ext,
    input  logic          mdr_drv_int,
    input  logic          mdr_drv_ext,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          wait_done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wdata_oe,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done,
    output logic          stall,
    output logic          strobe_err
);

    strobe_t       stb;
    logic          legal;
    logic          busy;
    logic [DW-1:0] mdr_val;

    // Gather the strobes into one bundle.
    always_comb begin
        stb.mar_ld      = mar_ld;
        stb.mdr_ld_int  = mdr_ld_int;
        stb.mdr_ld_ext  = mdr_ld_ext;
        stb.mdr_drv_int = mdr_drv_int;
        stb.mdr_drv_ext = mdr_drv_ext;
        stb.rd          = rd_req;
        stb.wr          = wr_req;
        stb.wt          = wait_done;
    end

    mpu_strobe_check u_check (
        .stb   (stb),
        .busy  (busy),
        .legal (legal)
    );

    mpu_req_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (stb),
        .legal      (legal),
        .mem_done   (mem_done),
        .busy       (busy),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .stall      (stall),
        .strobe_err (strobe_err)
    );

    mpu_data_path #(.AW(AW), .DW(DW)) u_data (
        .clk          (clk),
        .rst_n        (rst_n),
        .stb          (stb),
        .legal        (legal),
        .mem_done     (mem_done),
        .ibus_in      (ibus_in),
        .mem_rdata    (mem_rdata),
        .mem_addr     (mem_addr),
        .mdr_val      (mdr_val),
        .ibus_oe      (ibus_oe),
        .mem_wdata_oe (mem_wdata_oe)
    );

    // Both data outputs show the data register.
    always_comb begin
        ibus_out  = mdr_val;
        mem_wdata = mdr_val;
    end

    AST_ILLEGAL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wait_done) |-> !stall); // R9

endmodule

// File: tb/sim_mem_port_unit.sv
`timescale 1ns/1ps
module sim_mem_port_unit;

    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] ibus_in, ibus_out, mem_wdata, mem_rdata;
    logic          ibus_oe, mem_wdata_oe;
    logic          mar_ld, mdr_ld_int, mdr_ld_ext, mdr_drv_int, mdr_drv_ext;
    logic          rd_req, wr_req, wait_done, mem_done;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr, stall, strobe_err;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] exp_mar;
    logic [DW-1:0] exp_mdr;

    always #2.5 clk = ~clk;

    mem_port_unit #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .ibus_out(ibus_out),
        .ibus_oe(ibus_oe), .mar_ld(mar_ld), .mdr_ld_int(mdr_ld_int),
        .mdr_ld_ext(mdr_ld_ext), .mdr_drv_int(mdr_drv_int),
        .mdr_drv_ext(mdr_drv_ext), .rd_req(rd_req), .wr_req(wr_req),
        .wait_done(wait_done), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .stall(stall),
        .strobe_err(strobe_err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit order: 0 mar,1 ld_int,2 ld_ext,3 drv_int,4 drv_ext,5 rd,6 wr,7 wait
    task automatic set_stb(input logic [7:0] s);
        mar_ld = s[0]; mdr_ld_int = s[1]; mdr_ld_ext = s[2]; mdr_drv_int = s[3];
        mdr_drv_ext = s[4]; rd_req = s[5]; wr_req = s[6]; wait_done = s[7];
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; set_stb(8'h00); ibus_in = '0; mem_rdata = '0; mem_done = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mem_rd && !mem_wr && !stall && !strobe_err, "R1 flags", {mem_rd, mem_wr, stall, strobe_err}, 0);
        chk(mem_addr == 0 && ibus_out == 0, "R1 regs", {mem_addr, ibus_out}, 0);
        rst_n = 1'b1;
        tick();
        exp_mar = '0; exp_mdr = '0;

        // Sweep every strobe pattern with no request open (R2 R3 R6 R8 R9)
        for (int s = 0; s < 256; s++) begin
            logic [7:0] b;
            logic lg;
            logic [DW-1:0] v;
            b = s[7:0];
            v = s[7:0] ^ 8'hA5;
            lg = !(b[5] && b[6]) && !((b[5] || b[6]) && b[7]) &&
                 !(b[1] && b[2]) && !(b[1] && b[3]);
            set_stb(b); ibus_in = v; mem_rdata = ~v; mem_done = 1'b0;
            #1;
            chk(ibus_oe == (b[3] && lg), "R3 ibus_oe", ibus_oe, b[3] && lg);
            chk(mem_wdata_oe == (b[4] && lg), "R6 wdata_oe", mem_wdata_oe, b[4] && lg);
            chk(!stall, "R7 no stall idle", stall, 0);
            tick();
            if (lg && b[0]) exp_mar = v[AW-1:0];
            if (lg && b[1]) exp_mdr = v;
            chk(strobe_err == !lg, "R8 err", strobe_err, !lg);
            chk(mem_addr == exp_mar, "R2 mar", mem_addr, exp_mar);
            chk(ibus_out == exp_mdr && mem_wdata == exp_mdr, "R5 mdr", ibus_out, exp_mdr);
            chk(mem_rd == (lg && b[5]), "R4 rd", mem_rd, lg && b[5]);
            chk(mem_wr == (lg && b[6]), "R9 wr", mem_wr, lg && b[6]);
            if (mem_rd || mem_wr) begin
                set_stb(8'h80); mem_done = 1'b1;
                tick();
                mem_done = 1'b0;
                chk(!mem_rd && !mem_wr, "R4 release", {mem_rd, mem_wr}, 0);
            end
        end

        // Read sequence with stalls
        set_stb(8'h21); ibus_in = 8'h0C; tick();
        exp_mar = 4'hC;
        chk(mem_rd && mem_addr == exp_mar, "R4 read open", mem_addr, exp_mar);
        // done outside a wait step: request must stay
        set_stb(8'h00); mem_done = 1'b1; tick(); mem_done = 1'b0;
        chk(mem_rd, "R4 held on early done", mem_rd, 1);
        // overlapping request is rejected
        set_stb(8'h40); tick();
        chk(strobe_err && mem_rd && !mem_wr, "R10 overlap", {strobe_err, mem_rd, mem_wr}, 6);
        mem_rdata = 8'h3E;
        for (int k = 0; k < 3; k++) begin
            set_stb(8'h84); #1;
            chk(stall, "R7 stall while waiting", stall, 1);
            tick();
            chk(mem_rd && ibus_out == exp_mdr, "R5 no load without done", ibus_out, exp_mdr);
        end
        set_stb(8'h84); mem_done = 1'b1; #1;
        chk(!stall, "R7 stall clears on done", stall, 1'b0);
        tick(); mem_done = 1'b0; exp_mdr = 8'h3E;
        chk(!mem_rd && ibus_out == 8'h3E, "R5 read capture", ibus_out, 8'h3E);

        // Write sequence
        set_stb(8'h01); ibus_in = 8'h07; tick(); exp_mar = 4'h7;
        set_stb(8'h42); ibus_in = 8'h9B; tick(); exp_mdr = 8'h9B;
        chk(mem_wr && !mem_rd && mem_addr == 4'h7, "R6 write open", mem_addr, 4'h7);
        set_stb(8'h90); #1;
        chk(stall && mem_wdata_oe && mem_wdata == 8'h9B, "R6 write drive", mem_wdata, 8'h9B);
        tick();
        mem_done = 1'b1; #1;
        chk(!stall, "R7 write done", stall, 0);
        tick(); mem_done = 1'b0;
        chk(!mem_wr, "R6 write release", mem_wr, 0);

        // Wait with nothing open must not stall
        set_stb(8'h80); #1;
        chk(!stall, "R7 wait idle", stall, 0);
        tick();
        set_stb(8'h00); tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule